// File: doc/BRIEF.md
# Serial Write Buffer Transmitter

The block shifts 4-bit words out of a chip on two pins: a serial clock and a serial data line. Each bit occupies two system clocks. The clock pin is low in the first and high in the second. Data changes only while the clock pin is low. Words leave least significant bit first.

There are two ways to feed it.

- **Automatic mode.** Software sets a mode bit, a base address and a 6-bit size field, then halts the processor. The block reads `size + 1` consecutive words from a RAM read port and sends them back to back. At the end it raises a completion status, clears the mode bit and pulses a wake signal.
- **Interactive mode.** Software loads a one-word buffer and sets a start bit. Each time the buffer moves into the shifter, an empty interrupt asks for the next word. When a word finishes and nothing is waiting, the completion status rises.

In both modes the completion status must be cleared by a dummy write to the buffer before another transfer may begin.

Nothing moves unless the enable input is high and the host port is in output mode.

Top module: `swb_tx`

## Requirements
- R1: After reset, both pins are low and `status_o`, `empty_irq_o`, `done_o`, `auto_o` and `start_o` are all 0.
- R2: While `en_i` or `port_out_i` is low, no transfer starts. An ongoing transfer is abandoned, and the clock pin is low one cycle after the gate drops.
- R3: Pin bit 0 of `swb_pins_o` carries the serial clock and pin bit 1 carries the serial data.
- R4: Each bit takes two cycles, clock low then clock high. Data is stable while the clock is high. Each word goes out bit 0 first.
- R5: In automatic mode, with `halt_i` high and the status clear, the block sends `size_i + 1` words. The words come from RAM addresses `base_i`, `base_i + 1`, and so on, with no gap between words.
- R6: When the last automatic word ends, the following happen together in the next cycle: `status_o` rises, `auto_o` clears and `done_o` pulses for exactly one cycle. That cycle is `2 + 8*N` cycles after the cycle in which `halt_i` was first seen high, where N is the number of words.
- R7: In interactive mode, moving the buffer into the shifter sets `empty_irq_o`. A buffer write clears it. A waiting word follows the current one with no gap. When a word ends with the buffer empty, `status_o` rises.
- R8: Writing 0 to the start bit during an interactive transfer stops it at once. The clock pin is low from the next cycle, and no further clock pulses follow.
- R9: A buffer write while `status_o` is high stores nothing and clears both `status_o` and `empty_irq_o`. Until that write happens, neither mode starts a new transfer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| en_i | input | 1 | Block enable |
| port_out_i | input | 1 | Host port is in output mode |
| auto_wr_i | input | 1 | Write strobe for the automatic-mode bit |
| auto_val_i | input | 1 | Value written to the automatic-mode bit |
| start_wr_i | input | 1 | Write strobe for the interactive start bit |
| start_val_i | input | 1 | Value written to the start bit |
| size_i | input | 6 | Automatic word count minus one |
| base_i | input | 7 | First RAM address of the automatic window |
| halt_i | input | 1 | Processor is halted |
| buf_wr_i | input | 1 | Write strobe for the one-word buffer |
| buf_data_i | input | 4 | Word written to the buffer |
| ram_addr_o | output | 7 | RAM read address |
| ram_data_i | input | 4 | RAM read data (combinational for `ram_addr_o`) |
| swb_pins_o | output | 2 | Bit 0 is the serial clock, bit 1 is the serial data |
| status_o | output | 1 | Transfer complete |
| empty_irq_o | output | 1 | Buffer empty interrupt request |
| done_o | output | 1 | One-cycle wake pulse at the end of an automatic transfer |
| auto_o | output | 1 | Automatic-mode bit |
| start_o | output | 1 | Interactive start bit |

## Verification
The checker relies on a few assumptions about the inputs.

- Writing 0 to the start bit is only checked while the automatic-mode bit is low.
- The RAM port answers in the same cycle as its address.
- A buffer write is taken as a dummy write only while the status is high.

The bench drives every input one cycle at a time from the falling clock edge. It never writes the start bit in the same cycle as a mode change. It leaves `halt_i` high only until the status is seen, and it changes the size and base only while the block is idle.

// File: rtl/swb_pkg.sv
package swb_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_PREP  = 2'd1,
        ST_AUTO  = 2'd2,
        ST_INTER = 2'd3
    } swb_state_e;

endpackage

// File: rtl/swb_shifter.sv
module swb_shifter #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load_i,
    input  logic         abort_i,
    input  logic [W-1:0] word_i,
    output logic         sclk_o,
    output logic         sdat_o,
    output logic         busy_o,
    output logic         last_o
);
    localparam int BC_W = (W > 1) ? $clog2(W) : 1;
    localparam logic [BC_W-1:0] LAST_BIT = BC_W'(W - 1);

    logic [W-1:0]    sh_d, sh_q;
    logic [BC_W-1:0] cnt_d, cnt_q;
    logic            ph_d, ph_q;
    logic            busy_d, busy_q;

    always_comb begin
        sh_d   = sh_q;
        cnt_d  = cnt_q;
        ph_d   = ph_q;
        busy_d = busy_q;
        if (abort_i) begin
            busy_d = 1'b0;
            ph_d   = 1'b0;
        end else if (load_i) begin
            sh_d   = word_i;
            cnt_d  = '0;
            ph_d   = 1'b0;
            busy_d = 1'b1;
        end else if (busy_q) begin
            if (!ph_q) begin
                ph_d = 1'b1;
            end else begin
                ph_d = 1'b0;
                if (cnt_q == LAST_BIT) begin
                    busy_d = 1'b0;
                end else begin
                    cnt_d = cnt_q + BC_W'(1);
                    sh_d  = sh_q >> 1;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sh_q   <= '0;
            cnt_q  <= '0;
            ph_q   <= 1'b0;
            busy_q <= 1'b0;
        end else begin
            sh_q   <= sh_d;
            cnt_q  <= cnt_d;
            ph_q   <= ph_d;
            busy_q <= busy_d;
        end
    end

    assign sclk_o = busy_q & ph_q;
    assign sdat_o = busy_q & sh_q[0];
    assign busy_o = busy_q;
    assign last_o = busy_q & ph_q & (cnt_q == LAST_BIT);

endmodule

// File: rtl/swb_addr_gen.sv
module swb_addr_gen #(
    parameter int ADDR_W = 7,
    parameter int SIZE_W = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              init_i,
    input  logic              adv_i,
    input  logic [ADDR_W-1:0] base_i,
    input  logic [SIZE_W-1:0] size_i,
    output logic [ADDR_W-1:0] addr_o,
    output logic              more_o
);
    localparam int CNT_W = SIZE_W + 1;

    logic [ADDR_W-1:0] addr_d, addr_q;
    logic [CNT_W-1:0]  rem_d, rem_q;

    always_comb begin
        addr_d = addr_q;
        rem_d  = rem_q;
        if (init_i) begin
            addr_d = base_i;
            rem_d  = {1'b0, size_i} + CNT_W'(1);
        end else if (adv_i) begin
            addr_d = addr_q + ADDR_W'(1);
            rem_d  = rem_q - CNT_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            addr_q <= '0;
            rem_q  <= '0;
        end else begin
            addr_q <= addr_d;
            rem_q  <= rem_d;
        end
    end

    assign addr_o = addr_q;
    assign more_o = (rem_q != '0);

endmodule

// File: rtl/swb_tx.sv
module swb_tx
    import swb_pkg::*;
#(
    parameter int WORD_W = 4,
    parameter int SIZE_W = 6,
    parameter int ADDR_W = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en_i,
    input  logic              port_out_i,
    input  logic              auto_wr_i,
    input  logic              auto_val_i,
    input  logic              start_wr_i,
    input  logic              start_val_i,
    input  logic [SIZE_W-1:0] size_i,
    input  logic [ADDR_W-1:0] base_i,
    input  logic              halt_i,
    input  logic              buf_wr_i,
    input  logic [WORD_W-1:0] buf_data_i,
    output logic [ADDR_W-1:0] ram_addr_o,
    input  logic [WORD_W-1:0] ram_data_i,
    output logic [1:0]        swb_pins_o,
    output logic              status_o,
    output logic              empty_irq_o,
    output logic              done_o,
    output logic              auto_o,
    output logic              start_o
);
    typedef struct packed {
        swb_state_e        st;
        logic              auto_m;
        logic              start_m;
        logic [WORD_W-1:0] buf_w;
        logic              buf_full;
        logic              irq;
        logic              status;
        logic              done;
    } ctl_t;

    ctl_t ctl_d, ctl_q;

    logic              active;
    logic              start_eff;
    logic              wr_store, wr_dummy;
    logic              ld, use_buf, abort;
    logic              ag_init, ag_adv, ag_more;
    logic [WORD_W-1:0] ld_word;
    logic              sh_sclk, sh_sdat, sh_busy, sh_last;

    always_comb begin
        active    = en_i & port_out_i;
        start_eff = start_wr_i ? start_val_i : ctl_q.start_m;
        wr_store  = buf_wr_i & ~ctl_q.status;
        wr_dummy  = buf_wr_i & ctl_q.status;

        ctl_d      = ctl_q;
        ctl_d.done = 1'b0;
        ld         = 1'b0;
        use_buf    = 1'b0;
        abort      = 1'b0;
        ag_init    = 1'b0;
        ag_adv     = 1'b0;
        ld_word    = ram_data_i;

        if (auto_wr_i)  ctl_d.auto_m  = auto_val_i;
        if (start_wr_i) ctl_d.start_m = start_val_i;

        unique case (ctl_q.st)
            ST_IDLE: begin
                if (active && !ctl_q.status) begin
                    if (ctl_q.auto_m && halt_i) begin
                        ag_init  = 1'b1;
                        ctl_d.st = ST_PREP;
                    end else if (ctl_q.start_m && !ctl_q.auto_m && ctl_q.buf_full) begin
                        use_buf  = 1'b1;
                        ctl_d.st = ST_INTER;
                    end
                end
            end
            ST_PREP: begin
                if (!active || !ctl_q.auto_m) begin
                    ctl_d.st = ST_IDLE;
                end else begin
                    ld       = 1'b1;
                    ag_adv   = 1'b1;
                    ctl_d.st = ST_AUTO;
                end
            end
            ST_AUTO: begin
                if (!active || !ctl_q.auto_m) begin
                    abort    = 1'b1;
                    ctl_d.st = ST_IDLE;
                end else if (sh_last) begin
                    if (ag_more) begin
                        ld     = 1'b1;
                        ag_adv = 1'b1;
                    end else begin
                        ctl_d.st     = ST_IDLE;
                        ctl_d.status = 1'b1;
                        ctl_d.auto_m = 1'b0;
                        ctl_d.done   = 1'b1;
                    end
                end
            end
            ST_INTER: begin
                if (!active || !start_eff) begin
                    abort    = 1'b1;
                    ctl_d.st = ST_IDLE;
                end else if (sh_last) begin
                    if (ctl_q.buf_full) begin
                        use_buf = 1'b1;
                    end else begin
                        ctl_d.st     = ST_IDLE;
                        ctl_d.status = 1'b1;
                    end
                end
            end
            default: ctl_d.st = ST_IDLE;
        endcase

        if (use_buf) begin
            ld        = 1'b1;
            ld_word   = ctl_q.buf_w;
            ctl_d.irq = 1'b1;
        end
        ctl_d.buf_full = ctl_q.buf_full & ~use_buf;

        if (wr_store) begin
            ctl_d.buf_w    = buf_data_i;
            ctl_d.buf_full = 1'b1;
            ctl_d.irq      = 1'b0;
        end
        if (wr_dummy) begin
            ctl_d.status = 1'b0;
            ctl_d.irq    = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q <= '{st: ST_IDLE, default: '0};
        end else begin
            ctl_q <= ctl_d;
        end
    end

    swb_addr_gen #(
        .ADDR_W (ADDR_W),
        .SIZE_W (SIZE_W)
    ) addr_gen_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .init_i (ag_init),
        .adv_i  (ag_adv),
        .base_i (base_i),
        .size_i (size_i),
        .addr_o (ram_addr_o),
        .more_o (ag_more)
    );

    swb_shifter #(
        .W (WORD_W)
    ) shifter_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .load_i  (ld),
        .abort_i (abort),
        .word_i  (ld_word),
        .sclk_o  (sh_sclk),
        .sdat_o  (sh_sdat),
        .busy_o  (sh_busy),
        .last_o  (sh_last)
    );

    assign swb_pins_o  = {sh_sdat & sh_busy, sh_sclk};
    assign status_o    = ctl_q.status;
    assign empty_irq_o = ctl_q.irq;
    assign done_o      = ctl_q.done;
    assign auto_o      = ctl_q.auto_m;
    assign start_o     = ctl_q.start_m;

endmodule

// File: rtl/swb_tx_chk.sv
module swb_tx_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       en_i,
    input logic       port_out_i,
    input logic       start_wr_i,
    input logic       start_val_i,
    input logic       buf_wr_i,
    input logic [1:0] swb_pins_o,
    input logic       status_o,
    input logic       empty_irq_o,
    input logic       done_o,
    input logic       auto_o
);
    // R4: the clock pin is high for one cycle per bit.
    p_sclk_one_cycle_r4: assert property (@(posedge clk) disable iff (!rst_n)
        swb_pins_o[0] |=> !swb_pins_o[0]);

    // R4: data holds while the clock is high.
    p_sdat_stable_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (swb_pins_o[0] && $past(swb_pins_o[0]) == 1'b0 && $past(rst_n))
            |-> swb_pins_o[1] == $past(swb_pins_o[1]));

    // R2: a dropped gate leaves the clock pin low next cycle.
    p_gate_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !(en_i && port_out_i) |=> !swb_pins_o[0]);

    // R6: the wake pulse lasts one cycle.
    p_done_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    // R6: the wake pulse comes with status set and the mode bit cleared.
    p_done_status_r6: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (status_o && !auto_o));

    // R8: clearing the start bit stops the clock at once.
    p_stop_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (start_wr_i && !start_val_i && !auto_o) |=> !swb_pins_o[0]);

    // R9: a dummy write clears status and the empty request.
    p_dummy_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (buf_wr_i && status_o) |=> (!status_o && !empty_irq_o));

endmodule

bind swb_tx swb_tx_chk chk_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .en_i        (en_i),
    .port_out_i  (port_out_i),
    .start_wr_i  (start_wr_i),
    .start_val_i (start_val_i),
    .buf_wr_i    (buf_wr_i),
    .swb_pins_o  (swb_pins_o),
    .status_o    (status_o),
    .empty_irq_o (empty_irq_o),
    .done_o      (done_o),
    .auto_o      (auto_o)
);

// File: tb/swb_tx_tb_top.sv
module swb_tx_tb_top;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       en_i = 1'b0, port_out_i = 1'b0;
    logic       auto_wr_i = 1'b0, auto_val_i = 1'b0;
    logic       start_wr_i = 1'b0, start_val_i = 1'b0;
    logic [5:0] size_i = '0;
    logic [6:0] base_i = '0;
    logic       halt_i = 1'b0;
    logic       buf_wr_i = 1'b0;
    logic [3:0] buf_data_i = '0;
    logic [6:0] ram_addr_o;
    logic [3:0] ram_data_i;
    logic [1:0] swb_pins_o;
    logic       status_o, empty_irq_o, done_o, auto_o, start_o;

    logic [3:0] ram [0:127];
    logic       rx [0:1023];
    int         rx_cnt = 0, hi_cnt = 0, done_cnt = 0;
    logic       prev_sclk = 1'b0;
    int         n_checks = 0, n_fail = 0, cyc = 0;
    bit         ended = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    assign ram_data_i = ram[ram_addr_o];

    swb_tx dut_i (
        .clk(clk), .rst_n(rst_n), .en_i(en_i), .port_out_i(port_out_i),
        .auto_wr_i(auto_wr_i), .auto_val_i(auto_val_i),
        .start_wr_i(start_wr_i), .start_val_i(start_val_i),
        .size_i(size_i), .base_i(base_i), .halt_i(halt_i),
        .buf_wr_i(buf_wr_i), .buf_data_i(buf_data_i),
        .ram_addr_o(ram_addr_o), .ram_data_i(ram_data_i),
        .swb_pins_o(swb_pins_o), .status_o(status_o), .empty_irq_o(empty_irq_o),
        .done_o(done_o), .auto_o(auto_o), .start_o(start_o)
    );

    // Receiver: captures data on each rising edge of the clock pin.
    always @(negedge clk) begin
        if (swb_pins_o[0]) hi_cnt++;
        if (swb_pins_o[0] && !prev_sclk && rx_cnt < 1024) begin
            rx[rx_cnt] = swb_pins_o[1];
            rx_cnt++;
        end
        prev_sclk = swb_pins_o[0];
        if (done_o) done_cnt++;
    end

    task automatic finish_run();
        if (!ended) begin
            ended = 1;
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
            $finish;
        end
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 100000) begin
            n_checks++; n_fail++;
            $display("FAIL watchdog: actual %0d cycles expected < 100000", cyc);
            finish_run();
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic tick(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic clear_rx();
        rx_cnt = 0; hi_cnt = 0; done_cnt = 0;
    endtask

    function automatic int rx_word(input int idx);
        return {rx[idx*4+3], rx[idx*4+2], rx[idx*4+1], rx[idx*4]};
    endfunction

    task automatic wr_auto(input bit v);
        auto_wr_i = 1'b1; auto_val_i = v; tick(1); auto_wr_i = 1'b0;
    endtask

    task automatic wr_start(input bit v);
        start_wr_i = 1'b1; start_val_i = v; tick(1); start_wr_i = 1'b0;
    endtask

    task automatic wr_buf(input logic [3:0] v);
        buf_wr_i = 1'b1; buf_data_i = v; tick(1); buf_wr_i = 1'b0;
    endtask

    // Halt and count cycles until status rises.
    task automatic halt_until_status(output int lat);
        lat = 0;
        halt_i = 1'b1;
        while (!status_o && lat < 2000) begin
            tick(1);
            lat++;
        end
        halt_i = 1'b0;
    endtask

    task automatic t_reset();
        chk(swb_pins_o == 2'b00, "R1 pins", swb_pins_o, 0);
        chk(!status_o && !empty_irq_o && !done_o, "R1 flags",
            {status_o, empty_irq_o, done_o}, 0);
        chk(!auto_o && !start_o, "R1 bits", {auto_o, start_o}, 0);
    endtask

    task automatic t_auto_burst();
        int lat;
        base_i = 7'd5; size_i = 6'd2;
        clear_rx();
        wr_auto(1'b1);
        halt_until_status(lat);
        chk(lat == 26, "R6 latency", lat, 26);
        chk(rx_cnt == 12, "R5 bit count", rx_cnt, 12);
        for (int w = 0; w < 3; w++)
            chk(rx_word(w) == int'(ram[5+w]), "R5 R3 word LSB first", rx_word(w), ram[5+w]);
        chk(hi_cnt == 12, "R4 one high cycle per bit", hi_cnt, 12);
        tick(2);
        chk(done_cnt == 1, "R6 single done pulse", done_cnt, 1);
        chk(!auto_o, "R6 auto bit cleared", auto_o, 0);
        chk(status_o, "R6 status high", status_o, 1);
        chk(!empty_irq_o, "R7 no empty irq in auto", empty_irq_o, 0);
    endtask

    task automatic t_rearm();
        int lat;
        clear_rx();
        wr_auto(1'b1);
        halt_i = 1'b1; tick(40); halt_i = 1'b0;
        chk(rx_cnt == 0, "R9 blocked without dummy write", rx_cnt, 0);
        chk(status_o && auto_o, "R9 state held", {status_o, auto_o}, 3);
        wr_buf(4'h9);
        chk(!status_o, "R9 dummy clears status", status_o, 0);
        base_i = 7'd20; size_i = 6'd0;
        clear_rx();
        halt_until_status(lat);
        chk(lat == 10, "R6 latency one word", lat, 10);
        chk(rx_cnt == 4 && rx_word(0) == int'(ram[20]), "R5 single word",
            rx_word(0), ram[20]);
        wr_buf(4'h0);
    endtask

    task automatic t_gate();
        clear_rx();
        en_i = 1'b0;
        wr_auto(1'b1);
        halt_i = 1'b1; tick(30);
        chk(rx_cnt == 0 && !status_o, "R2 enable low", rx_cnt, 0);
        en_i = 1'b1; port_out_i = 1'b0; tick(30);
        chk(rx_cnt == 0 && !status_o, "R2 port not output", rx_cnt, 0);
        halt_i = 1'b0; port_out_i = 1'b1;
        wr_auto(1'b0);
        tick(2);
    endtask

    task automatic t_interactive();
        int guard;
        clear_rx();
        wr_buf(4'hA);
        wr_start(1'b1);
        tick(1);
        chk(empty_irq_o, "R7 irq on buffer move", empty_irq_o, 1);
        wr_buf(4'h3);
        chk(!empty_irq_o, "R7 write clears irq", empty_irq_o, 0);
        guard = 0;
        while (!status_o && guard < 200) begin tick(1); guard++; end
        chk(rx_cnt == 8, "R7 two words", rx_cnt, 8);
        chk(rx_word(0) == 10 && rx_word(1) == 3, "R7 R4 words LSB first",
            rx_word(0) * 16 + rx_word(1), 16'hA3);
        chk(hi_cnt == 8, "R7 back to back", hi_cnt, 8);
        chk(empty_irq_o, "R7 irq at end", empty_irq_o, 1);
        // Dummy write stores nothing: a restart finds the buffer empty.
        wr_buf(4'h5);
        chk(!status_o && !empty_irq_o, "R9 dummy clears both",
            {status_o, empty_irq_o}, 0);
        clear_rx();
        tick(30);
        chk(rx_cnt == 0, "R9 dummy data not stored", rx_cnt, 0);
        wr_start(1'b0);
    endtask

    task automatic t_stop();
        int at_stop;
        clear_rx();
        wr_buf(4'hF);
        wr_start(1'b1);
        tick(3);
        wr_start(1'b0);
        at_stop = rx_cnt;
        chk(!swb_pins_o[0], "R8 clock low after stop", swb_pins_o[0], 0);
        tick(20);
        chk(rx_cnt == at_stop && rx_cnt < 4, "R8 no further bits", rx_cnt, at_stop);
        chk(!status_o, "R8 no completion", status_o, 0);
    endtask

    initial begin
        for (int a = 0; a < 128; a++) ram[a] = 4'((a * 7 + 3) % 16);
        tick(3);
        rst_n = 1'b1;
        tick(1);
        t_reset();
        en_i = 1'b1; port_out_i = 1'b1;
        tick(2);
        t_auto_burst();
        t_rearm();
        t_gate();
        t_interactive();
        t_stop();
        tick(5);
        finish_run();
    end

endmodule